// File: doc/BRIEF.md
# Configurable User-Defined Cell Parser

This block sits on the receive side of an ATM cell path and breaks a byte stream into the fields of an extended cell. Each cell may begin with an extra header of 1 to 12 bytes that carries switch-internal routing data. The standard 4-byte header follows it, then an optional HEC byte, then the 48-byte payload. An extra-header length of zero gives the plain standard cell, so a cell is 52 + X + H bytes long, where X is the extra-header length and H is 1 when HEC is present and 0 otherwise. The length ranges from 52 to 65 bytes.

Bytes arrive one per clock while `in_valid` is high, and `in_sop` marks the first byte of each cell. The parser presents the extra header, the standard header and the HEC on output registers, with a one-cycle `hdr_valid` pulse once all of them are complete. It forwards the payload as a byte stream framed by `pl_sop` and `pl_eop`. The format comes from two configuration inputs that stay static while traffic flows. The parser does not check the HEC and does not delineate cells. If a new start-of-cell arrives inside a cell, the cell in progress is abandoned and an error pulse is raised.

Top module: `udc_cell_parser`

## Requirements
- R1: After reset, `hdr_valid`, `pl_valid`, `pl_sop`, `pl_eop`, `abort_err` and `hec_present` are low, and `xhdr_out`, `hdr_out` and `hec_out` are zero.
- R2: A cell starts on a cycle with `in_valid` and `in_sop` both high. Bytes that arrive with `in_valid` high and `in_sop` low while no cell is open produce no output and change no output register.
- R3: Inside a cell, the fields come in this order: X extra-header bytes, 4 header bytes, the HEC byte when `cfg_hec_en` is 1, and 48 payload bytes. The cell closes after its 52+X+H-th byte.
- R4: X equals `cfg_xhdr_len`, except that values above 12 are treated as 12. X = 0 means there is no extra header.
- R5: The k-th extra-header byte (k from 0) appears on `xhdr_out[8k+7:8k]`. All of `xhdr_out` is cleared when a cell starts, so positions at or beyond X read zero.
- R6: The k-th standard-header byte appears on `hdr_out[31-8k:24-8k]`, so the first byte is in the top octet.
- R7: `hdr_valid` pulses for one cycle, exactly one clock after the last header byte is accepted. That byte is the HEC when `cfg_hec_en` is 1 and the 4th standard-header byte otherwise. On that pulse, `hec_present` takes the value of `cfg_hec_en`. `hec_out` holds the HEC byte, and it is zero when there is no HEC.
- R8: Each payload byte appears on `pl_data` with `pl_valid` high one clock after it is accepted. `pl_sop` is high with the first payload byte and `pl_eop` with the 48th.
- R9: A cycle with `in_valid` low is ignored whatever `in_sop` and `in_data` hold, and the cell resumes with the next valid byte.
- R10: A start-of-cell that arrives while a cell is open raises `abort_err` for one cycle, one clock later. That byte becomes byte 0 of a new cell, and the abandoned cell produces no further output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_xhdr_len | input | 4 | Extra-header length in bytes (0 to 12; larger values are clamped) |
| cfg_hec_en | input | 1 | 1: cell carries a HEC byte |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first byte of a cell |
| in_data | input | 8 | Input byte |
| xhdr_out | output | 96 | Captured extra header, byte k at bits 8k+7:8k |
| hdr_out | output | 32 | Captured standard header, first byte at bits 31:24 |
| hec_out | output | 8 | Captured HEC byte, zero when absent |
| hec_present | output | 1 | HEC setting of the last completed header |
| hdr_valid | output | 1 | One-cycle pulse: header fields complete |
| pl_valid | output | 1 | Payload byte valid |
| pl_data | output | 8 | Payload byte |
| pl_sop | output | 1 | First payload byte |
| pl_eop | output | 1 | 48th payload byte |
| abort_err | output | 1 | One-cycle pulse: cell abandoned by an early start-of-cell |

## Verification
The parser is run with the standard 53-byte cell, a 52-byte cell with no HEC, the longest 65-byte cell, and a mid-range extra header without HEC. These patterns separate errors in the field boundaries from errors in the HEC handling. A length value above 12 shows whether the clamp works. Idle cycles with noise on `in_sop` and `in_data`, inserted between the bytes of a cell, show whether the position advances only on valid bytes. Bytes without a start-of-cell, sent before and after cells, show whether a closed parser stays closed. Cells cut short by a new start-of-cell, once in the header and once in the payload, show whether the abort resynchronises on the new byte and drops the rest of the old cell.

// File: rtl/udc_pkg.sv
package udc_pkg;

  localparam int UDC_STD_HDR_LEN = 4;

  typedef enum logic [1:0] {
    FLD_XHDR = 2'd0,
    FLD_HDR  = 2'd1,
    FLD_HEC  = 2'd2,
    FLD_PAY  = 2'd3
  } udc_field_e;

  // Effective extra-header length: larger requests saturate at the maximum.
  function automatic int clamp_len(input int raw, input int max_len);
    return (raw > max_len) ? max_len : raw;
  endfunction

  // Bytes in one cell for a given extra-header length and HEC setting.
  function automatic int cell_len(input int xlen, input bit hec, input int pay_len);
    return xlen + UDC_STD_HDR_LEN + (hec ? 1 : 0) + pay_len;
  endfunction

endpackage

// File: rtl/udc_pos_counter.sv
module udc_pos_counter #(
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [POS_W-1:0] cell_len,
  output logic             byte_take,
  output logic             cell_start,
  output logic             cell_last,
  output logic             abort_det,
  output logic [POS_W-1:0] cur_pos
);

  logic             active_q;
  logic [POS_W-1:0] pos_q;

  assign cell_start = in_valid & in_sop;
  assign abort_det  = cell_start & active_q;
  assign byte_take  = in_valid & (in_sop | active_q);
  assign cur_pos    = in_sop ? '0 : pos_q;
  assign cell_last  = byte_take & (cur_pos == (cell_len - POS_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pos_q    <= '0;
    end else if (byte_take) begin
      if (cell_last) begin
        active_q <= 1'b0;
        pos_q    <= '0;
      end else begin
        active_q <= 1'b1;
        pos_q    <= cur_pos + POS_W'(1);
      end
    end
  end

endmodule

// File: rtl/udc_field_decode.sv
module udc_field_decode
  import udc_pkg::*;
#(
  parameter int POS_W = 7
) (
  input  logic             [POS_W-1:0] cur_pos,
  input  logic             [POS_W-1:0] xlen,
  input  logic                         hec_en,
  output udc_field_e                   fld,
  output logic             [POS_W-1:0] idx
);

  logic [POS_W-1:0] hdr_end;
  logic [POS_W-1:0] pay_base;

  assign hdr_end  = xlen + POS_W'(UDC_STD_HDR_LEN);
  assign pay_base = hdr_end + POS_W'(hec_en);

  always_comb begin
    if (cur_pos < xlen) begin
      fld = FLD_XHDR;
      idx = cur_pos;
    end else if (cur_pos < hdr_end) begin
      fld = FLD_HDR;
      idx = cur_pos - xlen;
    end else if (hec_en && (cur_pos == hdr_end)) begin
      fld = FLD_HEC;
      idx = '0;
    end else begin
      fld = FLD_PAY;
      idx = cur_pos - pay_base;
    end
  end

endmodule

// File: rtl/udc_hdr_capture.sv
module udc_hdr_capture
  import udc_pkg::*;
#(
  parameter int MAX_XHDR = 12,
  parameter int POS_W    = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     byte_take,
  input  logic                     cell_start,
  input  udc_field_e               fld,
  input  logic [POS_W-1:0]         idx,
  input  logic [7:0]               in_data,
  input  logic                     hec_en,
  output logic [MAX_XHDR*8-1:0]    xhdr_out,
  output logic [UDC_STD_HDR_LEN*8-1:0] hdr_out,
  output logic [7:0]               hec_out,
  output logic                     hec_present,
  output logic                     hdr_valid,
  output logic                     hdr_done
);

  localparam int HDR_W = UDC_STD_HDR_LEN * 8;

  logic       hec_q;
  logic [7:0] hec_byte_q;
  logic       hdr_valid_q;

  assign hdr_done = byte_take &
                    (((fld == FLD_HDR) && (idx == POS_W'(UDC_STD_HDR_LEN - 1)) && !hec_en) ||
                     (fld == FLD_HEC));

  // One register per extra-header byte, cleared at every cell start.
  for (genvar i = 0; i < MAX_XHDR; i++) begin : g_xbyte
    logic [7:0] b_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        b_q <= '0;
      end else if (byte_take && (fld == FLD_XHDR) && (idx == POS_W'(i))) begin
        b_q <= in_data;
      end else if (cell_start) begin
        b_q <= '0;
      end
    end
    assign xhdr_out[i*8 +: 8] = b_q;
  end

  // Standard header, first received byte in the top octet.
  for (genvar k = 0; k < UDC_STD_HDR_LEN; k++) begin : g_hbyte
    logic [7:0] b_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        b_q <= '0;
      end else if (byte_take && (fld == FLD_HDR) && (idx == POS_W'(k))) begin
        b_q <= in_data;
      end
    end
    assign hdr_out[HDR_W-1-8*k -: 8] = b_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hec_byte_q  <= '0;
      hec_q       <= 1'b0;
      hdr_valid_q <= 1'b0;
    end else begin
      hdr_valid_q <= hdr_done;
      if (byte_take && (fld == FLD_HEC)) begin
        hec_byte_q <= in_data;
      end else if (cell_start) begin
        hec_byte_q <= '0;
      end
      if (hdr_done) begin
        hec_q <= hec_en;
      end
    end
  end

  assign hec_out     = hec_byte_q;
  assign hec_present = hec_q;
  assign hdr_valid   = hdr_valid_q;

endmodule

// File: rtl/udc_payload_out.sv
module udc_payload_out
  import udc_pkg::*;
#(
  parameter int POS_W       = 7,
  parameter int PAYLOAD_LEN = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_take,
  input  udc_field_e       fld,
  input  logic [POS_W-1:0] idx,
  input  logic [7:0]       in_data,
  output logic             pl_valid,
  output logic [7:0]       pl_data,
  output logic             pl_sop,
  output logic             pl_eop
);

  logic pay_take;

  assign pay_take = byte_take & (fld == FLD_PAY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pl_valid <= 1'b0;
      pl_data  <= '0;
      pl_sop   <= 1'b0;
      pl_eop   <= 1'b0;
    end else begin
      pl_valid <= pay_take;
      pl_sop   <= pay_take && (idx == '0);
      pl_eop   <= pay_take && (idx == POS_W'(PAYLOAD_LEN - 1));
      if (pay_take) begin
        pl_data <= in_data;
      end
    end
  end

endmodule

// File: rtl/udc_cell_parser.sv
module udc_cell_parser
  import udc_pkg::*;
#(
  parameter int MAX_XHDR    = 12,
  parameter int PAYLOAD_LEN = 48,
  localparam int XCFG_W     = $clog2(MAX_XHDR + 1),
  localparam int MAX_CELL   = MAX_XHDR + UDC_STD_HDR_LEN + 1 + PAYLOAD_LEN,
  localparam int POS_W      = $clog2(MAX_CELL + 1),
  localparam int XHDR_W     = MAX_XHDR * 8,
  localparam int HDR_W      = UDC_STD_HDR_LEN * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XCFG_W-1:0] cfg_xhdr_len,
  input  logic              cfg_hec_en,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [7:0]        in_data,
  output logic [XHDR_W-1:0] xhdr_out,
  output logic [HDR_W-1:0]  hdr_out,
  output logic [7:0]        hec_out,
  output logic              hec_present,
  output logic              hdr_valid,
  output logic              pl_valid,
  output logic [7:0]        pl_data,
  output logic              pl_sop,
  output logic              pl_eop,
  output logic              abort_err
);

  // Named internal events, visible to the bound checker.
  logic             byte_take;
  logic             cell_start;
  logic             cell_last;
  logic             abort_det;
  logic             hdr_done;
  logic [POS_W-1:0] cur_pos;
  logic [POS_W-1:0] xlen_eff;
  logic [POS_W-1:0] cell_len_w;
  udc_field_e       fld;
  logic [POS_W-1:0] idx;
  logic             abort_q;

  assign xlen_eff   = POS_W'(clamp_len(int'(cfg_xhdr_len), MAX_XHDR));
  assign cell_len_w = POS_W'(cell_len(int'(xlen_eff), cfg_hec_en, PAYLOAD_LEN));

  udc_pos_counter #(.POS_W(POS_W)) u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sop     (in_sop),
    .cell_len   (cell_len_w),
    .byte_take  (byte_take),
    .cell_start (cell_start),
    .cell_last  (cell_last),
    .abort_det  (abort_det),
    .cur_pos    (cur_pos)
  );

  udc_field_decode #(.POS_W(POS_W)) u_dec (
    .cur_pos (cur_pos),
    .xlen    (xlen_eff),
    .hec_en  (cfg_hec_en),
    .fld     (fld),
    .idx     (idx)
  );

  udc_hdr_capture #(.MAX_XHDR(MAX_XHDR), .POS_W(POS_W)) u_hdr (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_take   (byte_take),
    .cell_start  (cell_start),
    .fld         (fld),
    .idx         (idx),
    .in_data     (in_data),
    .hec_en      (cfg_hec_en),
    .xhdr_out    (xhdr_out),
    .hdr_out     (hdr_out),
    .hec_out     (hec_out),
    .hec_present (hec_present),
    .hdr_valid   (hdr_valid),
    .hdr_done    (hdr_done)
  );

  udc_payload_out #(.POS_W(POS_W), .PAYLOAD_LEN(PAYLOAD_LEN)) u_pay (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_take (byte_take),
    .fld       (fld),
    .idx       (idx),
    .in_data   (in_data),
    .pl_valid  (pl_valid),
    .pl_data   (pl_data),
    .pl_sop    (pl_sop),
    .pl_eop    (pl_eop)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) abort_q <= 1'b0;
    else        abort_q <= abort_det;
  end

  assign abort_err = abort_q;

endmodule

// File: rtl/udc_cell_parser_chk.sv
module udc_cell_parser_chk #(
  parameter int PAYLOAD_LEN = 48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_sop,
  input logic       pl_valid,
  input logic       pl_sop,
  input logic       pl_eop,
  input logic       hdr_valid,
  input logic       hec_present,
  input logic [7:0] hec_out,
  input logic       abort_err,
  input logic       cell_last
);

  // Payload beat index counted independently of the design.
  int beat_cnt;
  int cur_beat;

  assign cur_beat = pl_sop ? 0 : beat_cnt + 1;

  always_ff @(posedge clk) begin
    if (!rst_n)        beat_cnt <= 0;
    else if (pl_valid) beat_cnt <= cur_beat;
  end

  // R8
  pl_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_sop || pl_eop) |-> pl_valid);

  // R8
  payload_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && pl_eop) |-> (cur_beat == PAYLOAD_LEN - 1));

  // R3
  cell_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_last |=> (pl_valid && pl_eop));

  // R10
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_err |-> $past(in_valid && in_sop));

  // R7
  hdr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !hdr_valid);

  // R7
  hec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && !hec_present) |-> (hec_out == 8'h00));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!pl_valid && !hdr_valid && !abort_err));

endmodule

bind udc_cell_parser udc_cell_parser_chk #(.PAYLOAD_LEN(PAYLOAD_LEN)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_sop      (in_sop),
  .pl_valid    (pl_valid),
  .pl_sop      (pl_sop),
  .pl_eop      (pl_eop),
  .hdr_valid   (hdr_valid),
  .hec_present (hec_present),
  .hec_out     (hec_out),
  .abort_err   (abort_err),
  .cell_last   (cell_last)
);

// File: tb/udc_cell_parser_tb_top.sv
`timescale 1ns/1ps
module udc_cell_parser_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_xhdr_len = '0;
  logic        cfg_hec_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_sop = 1'b0;
  logic [7:0]  in_data = '0;
  logic [95:0] xhdr_out;
  logic [31:0] hdr_out;
  logic [7:0]  hec_out;
  logic        hec_present, hdr_valid, pl_valid, pl_sop, pl_eop, abort_err;
  logic [7:0]  pl_data;

  int checks = 0;
  int fails  = 0;
  string scen = "R1";

  always #10 clk = ~clk;

  udc_cell_parser dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_xhdr_len(cfg_xhdr_len), .cfg_hec_en(cfg_hec_en),
    .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
    .xhdr_out(xhdr_out), .hdr_out(hdr_out), .hec_out(hec_out),
    .hec_present(hec_present), .hdr_valid(hdr_valid), .pl_valid(pl_valid),
    .pl_data(pl_data), .pl_sop(pl_sop), .pl_eop(pl_eop), .abort_err(abort_err)
  );

  // Behavioural reference state
  int          m_pos = 0;
  bit          m_open = 0;
  logic [7:0]  m_xh [12];
  logic [7:0]  m_hd [4];
  logic [7:0]  e_hec = '0;
  logic        e_hecp = 1'b0;
  logic        e_hv = 1'b0, e_ab = 1'b0, e_plv = 1'b0, e_sop = 1'b0, e_eop = 1'b0;
  logic [7:0]  e_pld = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s) %s: actual %0h expected %0h", req, scen, what, act, exp);
    end
  endtask

  function automatic logic [95:0] exp_xhdr();
    logic [95:0] v = '0;
    for (int i = 0; i < 12; i++) v[i*8 +: 8] = m_xh[i];
    return v;
  endfunction

  function automatic logic [31:0] exp_hdr();
    return {m_hd[0], m_hd[1], m_hd[2], m_hd[3]};
  endfunction

  task automatic compare();
    check(hdr_valid === e_hv, "R7", "hdr_valid", 96'(hdr_valid), 96'(e_hv));
    check(abort_err === e_ab, "R10", "abort_err", 96'(abort_err), 96'(e_ab));
    check(pl_valid === e_plv, "R8", "pl_valid", 96'(pl_valid), 96'(e_plv));
    if (e_plv) begin
      check(pl_data === e_pld, "R8", "pl_data", 96'(pl_data), 96'(e_pld));
      check(pl_sop === e_sop, "R8", "pl_sop", 96'(pl_sop), 96'(e_sop));
      check(pl_eop === e_eop, "R8", "pl_eop", 96'(pl_eop), 96'(e_eop));
    end
    check(xhdr_out === exp_xhdr(), "R5", "xhdr_out", xhdr_out, exp_xhdr());
    check(hdr_out === exp_hdr(), "R6", "hdr_out", 96'(hdr_out), 96'(exp_hdr()));
    check(hec_out === e_hec, "R7", "hec_out", 96'(hec_out), 96'(e_hec));
    check(hec_present === e_hecp, "R7", "hec_present", 96'(hec_present), 96'(e_hecp));
  endtask

  task automatic model(input logic v, input logic s, input logic [7:0] d);
    int x, tot, p, pi;
    e_hv = 0; e_ab = 0; e_plv = 0; e_sop = 0; e_eop = 0;
    if (!v) return;
    x   = (cfg_xhdr_len > 12) ? 12 : int'(cfg_xhdr_len);
    tot = 52 + x + (cfg_hec_en ? 1 : 0);
    if (s) begin
      if (m_open) e_ab = 1;
      m_open = 1;
      m_pos  = 0;
      for (int i = 0; i < 12; i++) m_xh[i] = '0;
      e_hec = '0;
    end
    if (!m_open) return;
    p = m_pos;
    if (p < x) m_xh[p] = d;
    else if (p < x + 4) begin
      m_hd[p - x] = d;
      if (p == x + 3 && !cfg_hec_en) begin e_hv = 1; e_hecp = 0; end
    end else if (cfg_hec_en && p == x + 4) begin
      e_hec = d; e_hv = 1; e_hecp = 1;
    end else begin
      pi = p - x - 4 - (cfg_hec_en ? 1 : 0);
      e_plv = 1; e_pld = d; e_sop = (pi == 0); e_eop = (pi == 47);
    end
    m_pos++;
    if (m_pos == tot) begin m_open = 0; m_pos = 0; end
  endtask

  task automatic tick(input logic v, input logic s, input logic [7:0] d);
    @(negedge clk);
    compare();
    in_valid = v; in_sop = s; in_data = d;
    model(v, s, d);
  endtask

  task automatic idle_noise();
    tick(1'b0, 1'($urandom), 8'($urandom));
  endtask

  // Sends nb bytes of a cell (nb below the length cuts the cell short).
  task automatic send_cell(input int nb, input bit gaps);
    for (int b = 0; b < nb; b++) begin
      if (gaps && ($urandom % 3 == 0)) idle_noise();
      tick(1'b1, b == 0, 8'($urandom));
    end
  endtask

  function automatic int full_len();
    int x = (cfg_xhdr_len > 12) ? 12 : int'(cfg_xhdr_len);
    return 52 + x + (cfg_hec_en ? 1 : 0);
  endfunction

  initial begin
    for (int i = 0; i < 12; i++) m_xh[i] = '0;
    for (int i = 0; i < 4; i++)  m_hd[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check({hdr_valid, pl_valid, pl_sop, pl_eop, abort_err, hec_present} === 6'b0,
          "R1", "pulses after reset", 96'({hdr_valid, pl_valid, pl_sop, pl_eop, abort_err, hec_present}), 96'(0));
    check(xhdr_out === '0 && hdr_out === '0 && hec_out === '0, "R1", "fields after reset",
          96'(hdr_out), 96'(0));

    scen = "R2"; // stray bytes while closed
    cfg_xhdr_len = 4'd0; cfg_hec_en = 1'b1;
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b0, 8'($urandom));

    scen = "R3"; // standard 53-byte cells back to back
    send_cell(full_len(), 0);
    send_cell(full_len(), 0);

    scen = "R4"; // no extra header, no HEC
    tick(1'b0, 1'b0, 8'h00);
    cfg_hec_en = 1'b0;
    send_cell(full_len(), 0);

    scen = "R5"; // longest cell
    tick(1'b0, 1'b0, 8'h00);
    cfg_xhdr_len = 4'd12; cfg_hec_en = 1'b1;
    send_cell(full_len(), 0);

    scen = "R6"; // mid-range extra header, shorter than the previous one
    tick(1'b0, 1'b0, 8'h00);
    cfg_xhdr_len = 4'd5; cfg_hec_en = 1'b0;
    send_cell(full_len(), 0);

    scen = "R4"; // clamp above 12
    tick(1'b0, 1'b0, 8'h00);
    cfg_xhdr_len = 4'd15; cfg_hec_en = 1'b1;
    send_cell(full_len(), 0);

    scen = "R9"; // idle cycles with noise inside cells
    tick(1'b0, 1'b0, 8'h00);
    cfg_xhdr_len = 4'd3;
    send_cell(full_len(), 1);
    send_cell(full_len(), 1);

    scen = "R10"; // abort in header, then in payload
    send_cell(6, 0);
    send_cell(30, 1);
    send_cell(full_len(), 0);

    scen = "R2"; // stray bytes after a closed cell
    for (int i = 0; i < 6; i++) tick(1'b1, 1'b0, 8'($urandom));
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 8'h00);
    tick(1'b0, 1'b0, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule